// File: doc/BRIEF.md
# 4:1:1 Chroma Bit-Serial Packer

This block takes a 4:2:2 YCbCr pixel stream, one sample per clock with chroma alternating Cb then Cr, and reformats it into the orthogonal 4:1:1 output format. In 4:1:1 mode every output pixel keeps its own 8-bit luma byte. Chroma is reduced to one Cb/Cr pair per group of four pixels, taken from the group's first pixel. That pair is sent two bits per component per pixel over four chroma lines, so the whole pair has been delivered once the group's fourth pixel is out.

Groups are aligned to the start of active video. The first active sample after the active flag rises is always pixel 0 of a group. A format select input picks 4:1:1 or plain 4:2:2 output, and the choice travels with each sample. The horizontal sync and active flags go through on every line. Luma, the flags and chroma all leave the block a fixed three clocks after they enter, so downstream timing does not depend on the format.

Active runs are expected to hold an even number of samples, as every 4:2:2 line does. A run that stops partway through a group still emits its pixels using the pair that group captured.

Top module: `yuv411_packer`

## Requirements
- R1: `out_luma`, `out_hsync` and `out_active` equal `in_luma`, `in_hsync` and `in_active` from exactly 3 clocks earlier, on every line and in both formats.
- R2: When the sample entered with `fmt_411` = 0, `out_chroma` equals that sample's `in_chroma` byte unchanged, 3 clocks later, whether the sample was active or blanking.
- R3: The group phase counts 0,1,2,3,0,... over active samples. It restarts at 0 on the first active sample after each rise of `in_active`, so a short final group on one line does not shift the next line.
- R4: In 4:1:1 mode the group's Cb is the chroma byte of group pixel 0 and its Cr is the chroma byte of group pixel 1. The chroma bytes that arrive on pixels 2 and 3 have no effect on the output.
- R5: In 4:1:1 mode, `out_chroma[3]` carries Cb bits 7, 5, 3, 1 and `out_chroma[2]` carries Cb bits 6, 4, 2, 0, on group pixels 0, 1, 2, 3 respectively.
- R6: In 4:1:1 mode, `out_chroma[1]` carries Cr bits 7, 5, 3, 1 and `out_chroma[0]` carries Cr bits 6, 4, 2, 0, on group pixels 0, 1, 2, 3 respectively.
- R7: In 4:1:1 mode, `out_chroma[7:4]` is 0 on every output sample.
- R8: In 4:1:1 mode, a blanking sample (`in_active` = 0) produces `out_chroma` = 0x00.
- R9: `fmt_411` is taken per sample at the input. A change in the middle of a line affects only the samples entered after it, and the group phase and the captured Cb/Cr pair carry on across the change.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_411 | input | 1 | 1 = 4:1:1 output, 0 = 4:2:2 pass-through; applies to the sample on the inputs this cycle |
| in_hsync | input | 1 | Horizontal sync of the input sample |
| in_active | input | 1 | Active-video flag of the input sample |
| in_luma | input | 8 | Luma byte |
| in_chroma | input | 8 | Multiplexed chroma byte (Cb on even active samples, Cr on odd) |
| out_hsync | output | 1 | Horizontal sync, delayed 3 clocks |
| out_active | output | 1 | Active-video flag, delayed 3 clocks |
| out_luma | output | 8 | Luma, delayed 3 clocks |
| out_chroma | output | 8 | 4:2:2 chroma byte, or 4:1:1 chroma lines in bits 3:0 with bits 7:4 zero |

## Verification
Every result is due exactly three rising edges after the edge that captures its input sample, whatever the format and the group phase. The 4:1:1 nibble for group pixel 0 depends on a Cr byte that arrives one clock after that pixel, and the fixed latency covers that wait. When the driver applies a sample, it stamps the expected output with the current edge count plus three. The monitor samples one nanosecond after each rising edge and compares only the entries whose stamp matches that edge, so a result that comes a cycle early or late is reported as a miscompare. The bench computes the expected nibbles by shifting the group's Cb and Cr left by twice the pixel index and taking the top two bits.

// File: rtl/yp_pkg.sv
package yp_pkg;

  // Sample and grouping geometry
  localparam int unsigned YP_W     = 8;               // bits per luma / chroma sample
  localparam int unsigned YP_GRP   = 4;               // pixels per 4:1:1 group
  localparam int unsigned YP_PH_W  = $clog2(YP_GRP);  // group phase width
  localparam int unsigned YP_BPP   = YP_W / YP_GRP;   // bits of each component sent per pixel
  localparam int unsigned YP_NIB_W = 2 * YP_BPP;      // chroma lines used in 4:1:1 mode
  localparam int unsigned YP_LAT   = 3;               // input-to-output latency in clocks

  typedef logic [YP_PH_W-1:0] yp_phase_t;

  // One sample as it moves down the alignment pipeline
  typedef struct packed {
    logic             fmt;
    logic             hs;
    logic             act;
    yp_phase_t        ph;
    logic [YP_W-1:0]  y;
    logic [YP_W-1:0]  c;
  } yp_sample_t;

  // Chroma lines for one pixel of a group. Pixel ph sends the component
  // bits from position YP_W-1-YP_BPP*ph downwards; Cb bits go on the
  // upper lines and Cr bits on the lower lines.
  function automatic logic [YP_NIB_W-1:0] serial_nibble(
    input logic [YP_W-1:0] cb,
    input logic [YP_W-1:0] cr,
    input yp_phase_t       ph
  );
    logic [YP_NIB_W-1:0] n;
    int top;
    top = int'(YP_W) - 1 - int'(YP_BPP) * int'(ph);
    n = '0;
    for (int k = 0; k < int'(YP_BPP); k++) begin
      n[int'(YP_NIB_W) - 1 - k] = cb[top - k];
      n[int'(YP_BPP) - 1 - k]   = cr[top - k];
    end
    return n;
  endfunction

endpackage

// File: rtl/yp_phase_tracker.sv
module yp_phase_tracker
  import yp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      act_i,
  output yp_phase_t ph_o,        // phase of the sample on the inputs now
  output logic      grp_start_o, // active sample at group phase 0
  output logic      pair_end_o   // active sample at group phase 1
);

  logic      act_prev;
  yp_phase_t ph_next_q;
  logic      act_rise;

  assign act_rise    = act_i & ~act_prev;
  assign ph_o        = act_rise ? yp_phase_t'(0) : ph_next_q;
  assign grp_start_o = act_i && (ph_o == yp_phase_t'(0));
  assign pair_end_o  = act_i && (ph_o == yp_phase_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_prev  <= 1'b0;
      ph_next_q <= '0;
    end else begin
      act_prev <= act_i;
      if (act_i) begin
        ph_next_q <= ph_o + yp_phase_t'(1);
      end
    end
  end

endmodule

// File: rtl/yp_chroma_latch.sv
module yp_chroma_latch
  import yp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            grp_start_i,
  input  logic            pair_end_i,
  input  logic [YP_W-1:0] chroma_i,
  output logic [YP_W-1:0] cb_o,
  output logic [YP_W-1:0] cr_o
);

  // Cb waits here for its Cr partner. The pair is then transferred as a
  // whole, so the group being serialized keeps its values while the next
  // Cb is already arriving.
  logic [YP_W-1:0] cb_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cb_hold <= '0;
      cb_o    <= '0;
      cr_o    <= '0;
    end else begin
      if (grp_start_i) begin
        cb_hold <= chroma_i;
      end
      if (pair_end_i) begin
        cb_o <= cb_hold;
        cr_o <= chroma_i;
      end
    end
  end

endmodule

// File: rtl/yp_delay_line.sv
module yp_delay_line #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] regs [DEPTH];

  for (genvar i = 0; i < int'(DEPTH); i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) regs[i] <= '0;
        else        regs[i] <= d_i;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) regs[i] <= '0;
        else        regs[i] <= regs[i-1];
      end
    end
  end

  assign q_o = regs[DEPTH-1];

endmodule

// File: rtl/yp_out_stage.sv
module yp_out_stage
  import yp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  yp_sample_t      s_i,
  input  logic [YP_W-1:0] cb_i,
  input  logic [YP_W-1:0] cr_i,
  output logic            hs_o,
  output logic            act_o,
  output logic [YP_W-1:0] y_o,
  output logic [YP_W-1:0] c_o
);

  logic [YP_W-1:0] c_next;

  always_comb begin
    if (!s_i.fmt) begin
      c_next = s_i.c;
    end else if (s_i.act) begin
      c_next = {{(YP_W-YP_NIB_W){1'b0}}, serial_nibble(cb_i, cr_i, s_i.ph)};
    end else begin
      c_next = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_o  <= 1'b0;
      act_o <= 1'b0;
      y_o   <= '0;
      c_o   <= '0;
    end else begin
      hs_o  <= s_i.hs;
      act_o <= s_i.act;
      y_o   <= s_i.y;
      c_o   <= c_next;
    end
  end

endmodule

// File: rtl/yuv411_packer.sv
module yuv411_packer
  import yp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fmt_411,
  input  logic            in_hsync,
  input  logic            in_active,
  input  logic [YP_W-1:0] in_luma,
  input  logic [YP_W-1:0] in_chroma,
  output logic            out_hsync,
  output logic            out_active,
  output logic [YP_W-1:0] out_luma,
  output logic [YP_W-1:0] out_chroma
);

  localparam int unsigned PRE_DEPTH = YP_LAT - 1;
  localparam int unsigned SAMPLE_W  = $bits(yp_sample_t);

  // Named internal events, visible to the checker
  yp_phase_t       ph_cur;
  logic            grp_start;
  logic            pair_end;
  logic [YP_W-1:0] grp_cb;
  logic [YP_W-1:0] grp_cr;

  yp_sample_t          s_in;
  logic [SAMPLE_W-1:0] s_dly_bits;
  yp_sample_t          s_dly;

  yp_phase_tracker u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .act_i       (in_active),
    .ph_o        (ph_cur),
    .grp_start_o (grp_start),
    .pair_end_o  (pair_end)
  );

  yp_chroma_latch u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .grp_start_i (grp_start),
    .pair_end_i  (pair_end),
    .chroma_i    (in_chroma),
    .cb_o        (grp_cb),
    .cr_o        (grp_cr)
  );

  always_comb begin
    s_in.fmt = fmt_411;
    s_in.hs  = in_hsync;
    s_in.act = in_active;
    s_in.ph  = ph_cur;
    s_in.y   = in_luma;
    s_in.c   = in_chroma;
  end

  yp_delay_line #(
    .W     (SAMPLE_W),
    .DEPTH (PRE_DEPTH)
  ) u_align (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (s_in),
    .q_o   (s_dly_bits)
  );

  assign s_dly = yp_sample_t'(s_dly_bits);

  yp_out_stage u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .s_i   (s_dly),
    .cb_i  (grp_cb),
    .cr_i  (grp_cr),
    .hs_o  (out_hsync),
    .act_o (out_active),
    .y_o   (out_luma),
    .c_o   (out_chroma)
  );

endmodule

// File: rtl/yp_packer_chk.sv
module yp_packer_chk
  import yp_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            fmt_411,
  input logic            in_hsync,
  input logic            in_active,
  input logic [YP_W-1:0] in_luma,
  input logic [YP_W-1:0] in_chroma,
  input logic            out_hsync,
  input logic            out_active,
  input logic [YP_W-1:0] out_luma,
  input logic [YP_W-1:0] out_chroma,
  input yp_phase_t       ph_cur,
  input logic            grp_start,
  input logic            pair_end
);

  // Counts the edges since reset so that $past never reaches before reset
  logic [1:0] warm;
  logic       ready;

  always_ff @(posedge clk) begin
    if (!rst_n)              warm <= '0;
    else if (warm != 2'd3)   warm <= warm + 2'd1;
  end
  assign ready = (warm == 2'd3);

  p_fixed_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (out_luma == $past(in_luma, 3)) && (out_hsync == $past(in_hsync, 3))
              && (out_active == $past(in_active, 3)));

  p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !$past(fmt_411, 3)) |-> (out_chroma == $past(in_chroma, 3)));

  p_phase_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_active) |-> (ph_cur == yp_phase_t'(0)));

  p_pair_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pair_end |-> $past(grp_start));

  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(fmt_411, 3)) |-> (out_chroma[YP_W-1:YP_NIB_W] == '0));

  p_blank_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(fmt_411, 3) && !$past(in_active, 3)) |-> (out_chroma == '0));

endmodule

bind yuv411_packer yp_packer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fmt_411    (fmt_411),
  .in_hsync   (in_hsync),
  .in_active  (in_active),
  .in_luma    (in_luma),
  .in_chroma  (in_chroma),
  .out_hsync  (out_hsync),
  .out_active (out_active),
  .out_luma   (out_luma),
  .out_chroma (out_chroma),
  .ph_cur     (ph_cur),
  .grp_start  (grp_start),
  .pair_end   (pair_end)
);

// File: tb/yuv411_packer_tb_top.sv
module yuv411_packer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fmt_411 = 1'b0;
  logic       in_hsync = 1'b0;
  logic       in_active = 1'b0;
  logic [7:0] in_luma = 8'h00;
  logic [7:0] in_chroma = 8'h00;
  logic       out_hsync;
  logic       out_active;
  logic [7:0] out_luma;
  logic [7:0] out_chroma;

  always #2 clk = ~clk;   // 250 MHz

  yuv411_packer dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt_411    (fmt_411),
    .in_hsync   (in_hsync),
    .in_active  (in_active),
    .in_luma    (in_luma),
    .in_chroma  (in_chroma),
    .out_hsync  (out_hsync),
    .out_active (out_active),
    .out_luma   (out_luma),
    .out_chroma (out_chroma)
  );

  typedef struct {
    int         due;
    logic       hs;
    logic       act;
    logic [7:0] y;
    logic [7:0] c;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares every entry whose due edge has just passed
  always @(posedge clk) begin
    #1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      bit   bad;
      e = q.pop_front();
      bad = 1'b0;
      n_vec++;
      if (e.due != cyc) begin
        $display("FAIL R1 timing: entry due at edge %0d examined at %0d", e.due, cyc);
        bad = 1'b1;
      end
      if (out_luma !== e.y || out_hsync !== e.hs || out_active !== e.act) begin
        $display("FAIL R1 luma/sync: got y=%h hs=%b act=%b, expected y=%h hs=%b act=%b",
                 out_luma, out_hsync, out_active, e.y, e.hs, e.act);
        bad = 1'b1;
      end
      if (out_chroma !== e.c) begin
        $display("FAIL %s chroma: got %h, expected %h", e.tag, out_chroma, e.c);
        bad = 1'b1;
      end
      if (bad) n_bad++;
    end
  end

  // Driver: applies one sample and queues its expected result
  task automatic drive(input logic hs, input logic act, input logic [7:0] y,
                       input logic [7:0] c, input logic fmt,
                       input logic [7:0] exp_c, input string tag);
    exp_t e;
    @(negedge clk);
    in_hsync  = hs;
    in_active = act;
    in_luma   = y;
    in_chroma = c;
    fmt_411   = fmt;
    e.due = cyc + 3;
    e.hs  = hs;
    e.act = act;
    e.y   = y;
    e.c   = exp_c;
    e.tag = tag;
    q.push_back(e);
  endtask

  // Group pixel p shows the two top bits of each component after a
  // left shift by 2*p (R5, R6); the upper lines stay zero (R7)
  function automatic logic [7:0] model_411(input logic [7:0] cb, input logic [7:0] cr,
                                           input int p);
    logic [7:0] cbs;
    logic [7:0] crs;
    cbs = cb << (2 * p);
    crs = cr << (2 * p);
    return {4'b0000, cbs[7], cbs[6], crs[7], crs[6]};
  endfunction

  // One line: nact active samples, the format switches from fmt_a to
  // fmt_b at sample sw (R9), then 6 blanking samples with sync on two
  task automatic run_line(input int nact, input int sw, input bit fmt_a,
                          input bit fmt_b, input bit fixed_pat);
    logic [7:0] ys [64];
    logic [7:0] cs [64];
    for (int i = 0; i < nact; i++) begin
      ys[i] = 8'($urandom_range(1, 254));
      if (fixed_pat) cs[i] = (i % 2 == 0) ? 8'hA5 : 8'h3C;
      else           cs[i] = 8'($urandom_range(1, 254));
    end
    for (int i = 0; i < nact; i++) begin
      bit         f;
      logic [7:0] ec;
      int         base;
      f = (i < sw) ? fmt_a : fmt_b;
      base = (i / 4) * 4;
      if (f) begin
        ec = model_411(cs[base], cs[base + 1], i % 4);
        drive(1'b0, 1'b1, ys[i], cs[i], f, ec, "R3 R4 R5 R6 R7 R9");
      end else begin
        drive(1'b0, 1'b1, ys[i], cs[i], f, cs[i], "R2 R9");
      end
    end
    for (int j = 0; j < 6; j++) begin
      drive(j < 2, 1'b0, 8'h10, 8'h80, fmt_b, fmt_b ? 8'h00 : 8'h80,
            fmt_b ? "R8" : "R2");
    end
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R10: reset clears all outputs
    repeat (4) @(negedge clk);
    in_luma   = 8'hFF;
    in_chroma = 8'hFF;
    in_hsync  = 1'b1;
    in_active = 1'b1;
    @(negedge clk);
    n_vec++;
    if (out_luma !== 8'h00 || out_chroma !== 8'h00 || out_hsync !== 1'b0 || out_active !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 reset: got y=%h c=%h hs=%b act=%b, expected all zero",
               out_luma, out_chroma, out_hsync, out_active);
    end
    in_luma   = 8'h00;
    in_chroma = 8'h00;
    in_hsync  = 1'b0;
    in_active = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // Idle samples after reset (R1, R2)
    for (int k = 0; k < 3; k++) drive(1'b0, 1'b0, 8'h10, 8'h80, 1'b0, 8'h80, "R2");

    run_line(8, 8, 1'b0, 1'b0, 1'b0);    // R2: plain 4:2:2
    run_line(8, 8, 1'b1, 1'b1, 1'b1);    // R5 R6: fixed bit pattern
    run_line(6, 6, 1'b1, 1'b1, 1'b0);    // R3: short final group
    run_line(12, 12, 1'b1, 1'b1, 1'b0);  // R3: next line restarts the phase
    run_line(12, 6, 1'b0, 1'b1, 1'b0);   // R9: 4:2:2 to 4:1:1 mid-group
    run_line(12, 4, 1'b1, 1'b0, 1'b0);   // R9: 4:1:1 to 4:2:2
    run_line(2, 2, 1'b1, 1'b1, 1'b0);    // R3: minimum line
    for (int l = 0; l < 20; l++) begin
      int n;
      n = 2 * int'($urandom_range(1, 20));
      run_line(n, int'($urandom_range(0, 40)), 1'($urandom), 1'($urandom), 1'b0);
    end
    for (int k = 0; k < 6; k++) drive(1'b0, 1'b0, 8'h10, 8'h80, 1'b1, 8'h00, "R8");

    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule